// File: doc/BRIEF.md
# Interprocessor Link Card Pair

This block models the two 16-bit parallel interface cards that one processor uses to talk to a second processor. One card launches words toward the far side and the other card takes in the words that arrive from it. The data lines are cross-connected, so either card can send a word and read back whatever the far side returns. Each card has its own instruction port. Through it the CPU can write the output buffer, read or merge the input buffer, set or clear the control state, set or clear the flag, test the flag for a skip, and reset control from the backplane.

A set-control instruction arms the card and, in the same step, sends the output buffer over a one-cycle strobe. When a word arrives at a card, the card stores it, drops its command bit and raises its flag. The service-request line follows that flag. A loopback mode joins the two local cards so that a card test needs no far side. In loopback, each card's set-control delivers its word to the other local card. External strobes are then neither sent nor taken.

Top module: `ipc_link_pair`

## Requirements
- R1: While reset is held and in the first cycle after it, control and command read 0. Flag, flag buffer and service request read 1. Both buffers are zero, so txWord reads 0. busOut, skip and txStrobe read 0.
- R2: An instruction with op code 3 (output) writes busIn into the card's output buffer, which appears on txWord one cycle later. It does not raise txStrobe.
- R3: An instruction with op code 6 (set control) sets control and command. One cycle later the card raises txStrobe for exactly one cycle, with txWord carrying the output buffer.
- R4: An instruction with op code 7 (clear control) clears control and command. The crs input does the same on both cards, and it wins over a set control given in the same cycle.
- R5: A cycle with rxStrobe high stores rxWord into the input buffer, clears command and sets flag and flag buffer. This clearing of command wins over a set control given in the same cycle.
- R6: Op code 4 (load) puts the input buffer on busOut one cycle later. Op code 5 (merge) puts the input buffer ORed with busIn there instead. In every other cycle busOut is 0.
- R7: Op code 0 without the hold/clear bit sets the flag. Any instruction with ioHc high clears the flag and flag buffer after it executes.
- R8: A flag set, whether from an arriving word, from loopback or from op code 0, wins over a flag clear requested by ioHc in the same cycle.
- R9: Op code 2 (skip if flag set) and op code 1 (skip if flag clear) give a one-cycle skip pulse when the flag matches the condition. Neither changes any card state.
- R10: srq always equals flag.
- R11: With diagMode high, a set control on one card copies its output buffer into the other local card's input buffer and sets that card's flag. No txStrobe is raised, and rxStrobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| diagMode | input | 1 | Loopback between the two local cards |
| crs | input | 1 | Backplane control reset, both cards |
| ioValid | input | 2 | Instruction present, per card (0 = receive card, 1 = send card) |
| ioOp | input | 2x3 | Instruction op code per card |
| ioHc | input | 2 | Hold/clear bit per card |
| busIn | input | 2x16 | CPU data bus toward each card |
| busOut | output | 2x16 | Data returned by load or merge |
| skip | output | 2 | One-cycle skip pulse |
| ctlBit | output | 2 | Control flip-flop |
| cmdBit | output | 2 | Command flip-flop |
| flag | output | 2 | Flag flip-flop |
| flagBuf | output | 2 | Flag buffer flip-flop |
| srq | output | 2 | Service request |
| txStrobe | output | 2 | Word launched toward the far side |
| txWord | output | 2x16 | Outgoing word (output buffer) |
| rxStrobe | input | 2 | Word arriving from the far side |
| rxWord | input | 2x16 | Arriving word |

## Verification
Every result is registered once. Flip-flop changes, busOut, skip and txStrobe therefore all show one cycle after the edge that sampled the instruction or the arriving word. txWord follows the output buffer, so it also changes one cycle after an output instruction. The bench drives each step at a falling edge and compares against its model at the next falling edge, which places every comparison one full edge after the stimulus. srq is compared with the flag model in every step.

// File: rtl/ipc_link_pkg.sv
package ipc_link_pkg;
  localparam int NCARD = 2;

  typedef enum logic [2:0] {
    OP_FLAG    = 3'd0,
    OP_SKIPCLR = 3'd1,
    OP_SKIPSET = 3'd2,
    OP_OUT     = 3'd3,
    OP_LOAD    = 3'd4,
    OP_MERGE   = 3'd5,
    OP_SETCTL  = 3'd6,
    OP_CLRCTL  = 3'd7
  } ioOp_e;

  typedef struct packed {
    logic loadObuf;
    logic takeRx;
    logic takeLoop;
    logic retLoad;
    logic retMerge;
  } dpStrobes_t;
endpackage

// File: rtl/ipc_link_ctrl.sv
module ipc_link_ctrl
  import ipc_link_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       diagMode,
  input  logic                       crs,
  input  logic [NCARD-1:0]           ioValid,
  input  logic [NCARD-1:0][2:0]      ioOp,
  input  logic [NCARD-1:0]           ioHc,
  input  logic [NCARD-1:0]           rxStrobe,
  output dpStrobes_t [NCARD-1:0]     strobes,
  output logic [NCARD-1:0]           ctlBit,
  output logic [NCARD-1:0]           cmdBit,
  output logic [NCARD-1:0]           flag,
  output logic [NCARD-1:0]           flagBuf,
  output logic [NCARD-1:0]           skip,
  output logic [NCARD-1:0]           txStrobe
);
  for (genvar k = 0; k < NCARD; k++) begin : g_card
    localparam int O = NCARD - 1 - k;
    logic doStc, doClc, doFlag, arrive, loopIn, setF, clrF, skipHit;

    always_comb begin
      doStc   = ioValid[k] && (ioOp[k] == OP_SETCTL);
      doClc   = ioValid[k] && (ioOp[k] == OP_CLRCTL);
      doFlag  = ioValid[k] && (ioOp[k] == OP_FLAG) && !ioHc[k];
      arrive  = rxStrobe[k] && !diagMode;
      loopIn  = diagMode && ioValid[O] && (ioOp[O] == OP_SETCTL);
      setF    = arrive || loopIn || doFlag;
      clrF    = ioValid[k] && ioHc[k];
      skipHit = ioValid[k] &&
                (((ioOp[k] == OP_SKIPSET) && flag[k]) ||
                 ((ioOp[k] == OP_SKIPCLR) && !flag[k]));
      strobes[k].loadObuf = ioValid[k] && (ioOp[k] == OP_OUT);
      strobes[k].takeRx   = arrive;
      strobes[k].takeLoop = loopIn;
      strobes[k].retLoad  = ioValid[k] && (ioOp[k] == OP_LOAD);
      strobes[k].retMerge = ioValid[k] && (ioOp[k] == OP_MERGE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctlBit[k]   <= 1'b0;
        cmdBit[k]   <= 1'b0;
        flag[k]     <= 1'b1;
        flagBuf[k]  <= 1'b1;
        skip[k]     <= 1'b0;
        txStrobe[k] <= 1'b0;
      end else begin
        if (crs || doClc)                 ctlBit[k] <= 1'b0;
        else if (doStc)                   ctlBit[k] <= 1'b1;
        if (crs || doClc || arrive)       cmdBit[k] <= 1'b0;
        else if (doStc)                   cmdBit[k] <= 1'b1;
        if (setF) begin
          flag[k]    <= 1'b1;
          flagBuf[k] <= 1'b1;
        end else if (clrF) begin
          flag[k]    <= 1'b0;
          flagBuf[k] <= 1'b0;
        end
        skip[k]     <= skipHit;
        txStrobe[k] <= doStc && !diagMode;
      end
    end
  end
endmodule

// File: rtl/ipc_link_dp.sv
module ipc_link_dp
  import ipc_link_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  dpStrobes_t [NCARD-1:0]        strobes,
  input  logic [NCARD-1:0][DATA_W-1:0]  busIn,
  input  logic [NCARD-1:0][DATA_W-1:0]  rxWord,
  output logic [NCARD-1:0][DATA_W-1:0]  busOut,
  output logic [NCARD-1:0][DATA_W-1:0]  txWord
);
  logic [NCARD-1:0][DATA_W-1:0] obuf;
  logic [NCARD-1:0][DATA_W-1:0] ibuf;

  for (genvar k = 0; k < NCARD; k++) begin : g_card
    localparam int O = NCARD - 1 - k;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        obuf[k]   <= '0;
        ibuf[k]   <= '0;
        busOut[k] <= '0;
      end else begin
        if (strobes[k].loadObuf) obuf[k] <= busIn[k];
        if (strobes[k].takeRx)        ibuf[k] <= rxWord[k];
        else if (strobes[k].takeLoop) ibuf[k] <= obuf[O];
        if (strobes[k].retLoad)       busOut[k] <= ibuf[k];
        else if (strobes[k].retMerge) busOut[k] <= ibuf[k] | busIn[k];
        else                          busOut[k] <= '0;
      end
    end

    assign txWord[k] = obuf[k];
  end
endmodule

// File: rtl/ipc_link_pair.sv
module ipc_link_pair
  import ipc_link_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          diagMode,
  input  logic                          crs,
  input  logic [NCARD-1:0]              ioValid,
  input  logic [NCARD-1:0][2:0]         ioOp,
  input  logic [NCARD-1:0]              ioHc,
  input  logic [NCARD-1:0][DATA_W-1:0]  busIn,
  output logic [NCARD-1:0][DATA_W-1:0]  busOut,
  output logic [NCARD-1:0]              skip,
  output logic [NCARD-1:0]              ctlBit,
  output logic [NCARD-1:0]              cmdBit,
  output logic [NCARD-1:0]              flag,
  output logic [NCARD-1:0]              flagBuf,
  output logic [NCARD-1:0]              srq,
  output logic [NCARD-1:0]              txStrobe,
  output logic [NCARD-1:0][DATA_W-1:0]  txWord,
  input  logic [NCARD-1:0]              rxStrobe,
  input  logic [NCARD-1:0][DATA_W-1:0]  rxWord
);
  dpStrobes_t [NCARD-1:0] strobes;

  ipc_link_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .diagMode(diagMode), .crs(crs),
    .ioValid(ioValid), .ioOp(ioOp), .ioHc(ioHc), .rxStrobe(rxStrobe),
    .strobes(strobes), .ctlBit(ctlBit), .cmdBit(cmdBit), .flag(flag),
    .flagBuf(flagBuf), .skip(skip), .txStrobe(txStrobe)
  );

  ipc_link_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .busIn(busIn),
    .rxWord(rxWord), .busOut(busOut), .txWord(txWord)
  );

  assign srq = flag;
endmodule

// File: rtl/ipc_link_checker.sv
module ipc_link_checker
  import ipc_link_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  diagMode,
  input logic                  crs,
  input logic [NCARD-1:0]      ioValid,
  input logic [NCARD-1:0][2:0] ioOp,
  input logic [NCARD-1:0]      ioHc,
  input logic [NCARD-1:0]      rxStrobe,
  input logic [NCARD-1:0]      ctlBit,
  input logic [NCARD-1:0]      cmdBit,
  input logic [NCARD-1:0]      flag,
  input logic [NCARD-1:0]      txStrobe
);
  for (genvar k = 0; k < NCARD; k++) begin : g_chk
    localparam int O = NCARD - 1 - k;

    assert_tx_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ioValid[k] && ioOp[k] == OP_SETCTL && !diagMode) |=> txStrobe[k]);

    assert_crs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      crs |=> (!ctlBit[k] && !cmdBit[k]));

    assert_rx_arrive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rxStrobe[k] && !diagMode) |=> (flag[k] && !cmdBit[k]));

    assert_hc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ioValid[k] && ioHc[k] && !(rxStrobe[k] && !diagMode) &&
       !(diagMode && ioValid[O] && ioOp[O] == OP_SETCTL)) |=> !flag[k]);

    assert_skip_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ioValid[k] && !ioHc[k] && !crs &&
       (ioOp[k] == OP_SKIPSET || ioOp[k] == OP_SKIPCLR) &&
       !(rxStrobe[k] && !diagMode) &&
       !(diagMode && ioValid[O] && ioOp[O] == OP_SETCTL))
      |=> (flag[k] == $past(flag[k]) && ctlBit[k] == $past(ctlBit[k]) &&
           cmdBit[k] == $past(cmdBit[k])));

    assert_loop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (diagMode && ioValid[k] && ioOp[k] == OP_SETCTL)
      |=> (flag[O] && !txStrobe[k]));
  end
endmodule

bind ipc_link_pair ipc_link_checker chk (.*);

// File: tb/ipc_link_pair_test.sv
module ipc_link_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic diagMode = 1'b0;
  logic crs = 1'b0;
  logic [1:0] ioValid = '0;
  logic [1:0][2:0] ioOp = '0;
  logic [1:0] ioHc = '0;
  logic [1:0][W-1:0] busIn = '0;
  logic [1:0] rxStrobe = '0;
  logic [1:0][W-1:0] rxWord = '0;
  logic [1:0][W-1:0] busOut, txWord;
  logic [1:0] skip, ctlBit, cmdBit, flag, flagBuf, srq, txStrobe;

  int checks = 0;
  int errors = 0;

  logic [1:0] mCtl, mCmd, mFlag, mSkip, mTx;
  logic [1:0][W-1:0] mIbuf, mObuf, mBus;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_link_pair #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .diagMode(diagMode), .crs(crs),
    .ioValid(ioValid), .ioOp(ioOp), .ioHc(ioHc), .busIn(busIn),
    .busOut(busOut), .skip(skip), .ctlBit(ctlBit), .cmdBit(cmdBit),
    .flag(flag), .flagBuf(flagBuf), .srq(srq), .txStrobe(txStrobe),
    .txWord(txWord), .rxStrobe(rxStrobe), .rxWord(rxWord)
  );

  task automatic chk(string tag, string what, int k, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s card%0d %s: actual %h expected %h", tag, k, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int k = 0; k < 2; k++) begin
      chk(tag, "ctl", k, W'(ctlBit[k]), W'(mCtl[k]));
      chk(tag, "cmd", k, W'(cmdBit[k]), W'(mCmd[k]));
      chk(tag, "flag", k, W'(flag[k]), W'(mFlag[k]));
      chk(tag, "flagBuf", k, W'(flagBuf[k]), W'(mFlag[k]));
      chk({tag, "/R10"}, "srq", k, W'(srq[k]), W'(mFlag[k]));
      chk(tag, "skip", k, W'(skip[k]), W'(mSkip[k]));
      chk(tag, "txStrobe", k, W'(txStrobe[k]), W'(mTx[k]));
      chk(tag, "txWord", k, txWord[k], mObuf[k]);
      chk(tag, "busOut", k, busOut[k], mBus[k]);
    end
  endtask

  task automatic modelReset();
    mCtl = '0; mCmd = '0; mFlag = '1; mSkip = '0; mTx = '0;
    mIbuf = '0; mObuf = '0; mBus = '0;
  endtask

  task automatic modelStep();
    logic [1:0] nCtl, nCmd, nFlag;
    logic [1:0][W-1:0] nIbuf, nObuf;
    for (int k = 0; k < 2; k++) begin
      int o = 1 - k;
      logic v, stc, clc, arrive, loopIn;
      v = ioValid[k];
      stc = v && ioOp[k] == 3'd6;
      clc = v && ioOp[k] == 3'd7;
      arrive = rxStrobe[k] && !diagMode;
      loopIn = diagMode && ioValid[o] && ioOp[o] == 3'd6;
      mSkip[k] = v && ((ioOp[k] == 3'd2 && mFlag[k]) || (ioOp[k] == 3'd1 && !mFlag[k]));
      mBus[k] = (v && ioOp[k] == 3'd4) ? mIbuf[k] :
                (v && ioOp[k] == 3'd5) ? (mIbuf[k] | busIn[k]) : '0;
      mTx[k] = stc && !diagMode;
      nCtl[k] = (crs || clc) ? 1'b0 : stc ? 1'b1 : mCtl[k];
      nCmd[k] = (crs || clc || arrive) ? 1'b0 : stc ? 1'b1 : mCmd[k];
      nFlag[k] = (arrive || loopIn || (v && ioOp[k] == 3'd0 && !ioHc[k])) ? 1'b1 :
                 (v && ioHc[k]) ? 1'b0 : mFlag[k];
      nIbuf[k] = arrive ? rxWord[k] : loopIn ? mObuf[o] : mIbuf[k];
      nObuf[k] = (v && ioOp[k] == 3'd3) ? busIn[k] : mObuf[k];
    end
    mCtl = nCtl; mCmd = nCmd; mFlag = nFlag; mIbuf = nIbuf; mObuf = nObuf;
  endtask

  task automatic idle();
    ioValid = '0; ioOp = '0; ioHc = '0; busIn = '0;
    rxStrobe = '0; rxWord = '0; crs = 1'b0;
  endtask

  task automatic op(int k, logic [2:0] code, logic hc, logic [W-1:0] d);
    ioValid[k] = 1'b1; ioOp[k] = code; ioHc[k] = hc; busIn[k] = d;
  endtask

  task automatic step(string tag);
    modelStep();
    @(negedge clk);
    checkAll(tag);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    modelReset();
    idle();
    repeat (3) @(negedge clk);
    checkAll("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1");

    op(1, 3'd3, 1'b0, 16'hA5C3); step("R2");
    op(1, 3'd6, 1'b0, 16'h0); step("R3 stc");
    step("R3 strobe ends");
    op(0, 3'd0, 1'b1, 16'h0); step("R7 clear flag");
    op(0, 3'd0, 1'b0, 16'h0); step("R7 set flag");
    op(0, 3'd2, 1'b1, 16'h0); step("R7 hc on skip");
    op(0, 3'd6, 1'b0, 16'h0); rxStrobe[0] = 1'b1; rxWord[0] = 16'h1234; step("R5");
    op(0, 3'd4, 1'b0, 16'hFFFF); step("R6 load");
    op(0, 3'd5, 1'b0, 16'h00F0); step("R6 merge");
    op(0, 3'd2, 1'b0, 16'h0); op(1, 3'd1, 1'b0, 16'h0); step("R9 skips");
    op(0, 3'd1, 1'b0, 16'h0); op(1, 3'd0, 1'b1, 16'h0); step("R9 no skip");
    op(1, 3'd1, 1'b0, 16'h0); step("R9 skip clear");
    op(1, 3'd3, 1'b1, 16'h0); rxStrobe[1] = 1'b1; rxWord[1] = 16'h5A5A; step("R8");
    op(0, 3'd6, 1'b0, 16'h0); crs = 1'b1; step("R4 crs");
    op(1, 3'd6, 1'b0, 16'h0); step("R4 set");
    op(1, 3'd7, 1'b0, 16'h0); step("R4 clc");
    diagMode = 1'b1;
    op(0, 3'd3, 1'b0, 16'hBEEF); op(1, 3'd0, 1'b1, 16'h0); step("R11 prep");
    op(0, 3'd6, 1'b0, 16'h0); rxStrobe = 2'b11; rxWord[1] = 16'h1111; step("R11 loop");
    op(1, 3'd4, 1'b0, 16'h0); step("R11 read");
    diagMode = 1'b0;

    for (int n = 0; n < 3000; n++) begin
      if (n % 256 == 128) diagMode = ~diagMode;
      for (int k = 0; k < 2; k++) begin
        ioValid[k] = 1'($urandom % 2);
        ioOp[k] = 3'($urandom % 8);
        ioHc[k] = ($urandom % 4) == 0;
        busIn[k] = 16'($urandom);
        rxStrobe[k] = ($urandom % 5) == 0;
        rxWord[k] = 16'($urandom);
      end
      crs = ($urandom % 20) == 0;
      step("RND R1..R11 mix");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule